// File: doc/BRIEF.md
# Display Controller Register and Interrupt Block

This block is the software-visible control store of a raster display controller. A host reaches it through a simple request port that carries a valid strobe, a write flag, a byte offset, an access size and 32 bits of write data. Every request produces a one-cycle response with read data and an error flag. Inside the block sit the frame-buffer geometry words, a bus options word, the vertical and horizontal timing words, sync polarity, pixel format and three colour channel selectors. All of them are presented on a flat configuration bus for the timing generator and the fetch engine.

The block also holds the controller's interrupt state: a raw status word, a mask and a derived masked status. It drives one level-sensitive interrupt line. Raw bits are set either by software or by event strobes from the timing generator and the DMA engine. A command word carries the controller enable, and the block emits a single-cycle start or stop pulse only when that enable bit actually changes.

Top module: `dpy_ctrl_regs`

## Requirements
- R1: A request whose `req_bytes` is not 4 returns `rsp_err`=1 and read data 0, and a write with any other size changes no register.
- R2: Offset 0x000 is read-only and always reads 0x0001_0200. A write there returns an error and has no effect.
- R3: After reset every register reads 0, except offset 0x000 (0x0001_0200) and bus options at 0x110, which reads 0x0000_0410: four outstanding transfers in bits 11:8 and burst flag value 0x10 in the low bits.
- R4: The configuration words read back exactly as written, all 32 bits. Their offsets are 0x100 base, 0x104 line length, 0x108 line count, 0x10C pitch, 0x110 bus options, 0x200..0x21C the vertical then horizontal sync, back porch, data and front porch, 0x220 polarity, 0x240 pixel format, and 0x244/0x248/0x24C the red/green/blue selectors. They appear on `cfg_flat` in that order, with slot 0 in the low 32 bits.
- R5: A write to raw status at 0x010 sets the raw bits whose written value is 1 and leaves the others unchanged. Raw bits are bit 0 DMA end, bit 1 reserved (software-settable), bit 2 vsync and bit 3 underrun. Bits 31:4 read 0.
- R6: A write to clear at 0x014 clears the raw bits whose written value is 1. Reading 0x014 returns an error and data 0. An event strobe in the same cycle as a clear leaves its bit set.
- R7: The mask at 0x018 holds bits 3:0. The masked status at 0x01C reads raw AND mask, and a write there returns an error and is ignored. `irq_o` is high exactly while the masked status is non-zero.
- R8: A one-cycle strobe on `evt_dma_end`, `evt_vsync` or `evt_underrun` sets raw bit 0, 2 or 3 respectively at the next clock edge.
- R9: The command word at 0x230 stores all 32 bits, and bit 0 is the enable, shown on `ctrl_on`. A write that moves bit 0 from 0 to 1 gives one cycle of `start_pulse`, and one that moves it from 1 to 0 gives one cycle of `stop_pulse`. Any other write gives no pulse.
- R10: An access to an offset that names no register, including any offset with bits 1:0 non-zero, reads 0, changes nothing and returns `rsp_err`=1.
- R11: `rsp_valid` is high for exactly the one cycle after each cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset of the access |
| req_bytes | input | 3 | Access size in bytes; only 4 is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, 0 for writes and errors |
| rsp_err | output | 1 | Access was illegal and had no effect |
| evt_dma_end | input | 1 | DMA engine finished a frame |
| evt_vsync | input | 1 | Timing generator entered vertical sync |
| evt_underrun | input | 1 | Pixel buffer ran dry |
| irq_o | output | 1 | Level interrupt, high while masked status is non-zero |
| ctrl_on | output | 1 | Current controller enable |
| start_pulse | output | 1 | One cycle on enable rising |
| stop_pulse | output | 1 | One cycle on enable falling |
| cfg_flat | output | 576 | Eighteen 32-bit configuration words, slot 0 lowest |

## Verification
A corrupted raw or mask bit shows up at once on `irq_o` and on the next read of the masked status. The bench therefore sweeps every mask against every raw pattern and compares both the line and the status read in the response cycle. A decoder that drops or aliases an offset corrupts a neighbour's stored word. The bench catches this by sweeping every byte offset in the decoded range and then reading back every defined register. A wrong stored enable appears as a missing or extra start/stop pulse in the response cycle of the offending command write.

// File: rtl/dpy_regs_pkg.sv
// Shared constants and offset decoding for the display controller register block.
// Assumes a 12-bit byte offset space and 32-bit words.
package dpy_regs_pkg;
    localparam int ADDR_W = 12;
    localparam int DW     = 32;
    localparam int IRQ_W  = 4;
    localparam int NSLOT  = 18;
    localparam int SLOT_W = $clog2(NSLOT);

    localparam int IRQ_DMA_END  = 0;
    localparam int IRQ_RSV      = 1;
    localparam int IRQ_VSYNC    = 2;
    localparam int IRQ_UNDERRUN = 3;

    localparam logic [DW-1:0] ID_VALUE    = 32'h0001_0200;
    localparam logic [DW-1:0] BUSOPT_RST  = 32'h0000_0410;
    localparam int            BUSOPT_SLOT = 4;

    typedef enum logic [2:0] {
        K_NONE, K_ID, K_RAW, K_CLR, K_MASK, K_STAT, K_CMD, K_CFG
    } acc_kind_e;

    // Classify a byte offset.
    function automatic acc_kind_e kind_of(input logic [ADDR_W-1:0] a);
        case (a)
            12'h000: return K_ID;
            12'h010: return K_RAW;
            12'h014: return K_CLR;
            12'h018: return K_MASK;
            12'h01C: return K_STAT;
            12'h230: return K_CMD;
            12'h100, 12'h104, 12'h108, 12'h10C, 12'h110,
            12'h200, 12'h204, 12'h208, 12'h20C,
            12'h210, 12'h214, 12'h218, 12'h21C, 12'h220,
            12'h240, 12'h244, 12'h248, 12'h24C: return K_CFG;
            default: return K_NONE;
        endcase
    endfunction

    // Configuration slot of a byte offset (meaningful only for K_CFG).
    function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
        logic [SLOT_W-1:0] s;
        if (a[11:8] == 4'h1)        s = SLOT_W'(a[4:2]);
        else if (a[7:4] == 4'h4)    s = SLOT_W'(14 + a[3:2]);
        else                        s = SLOT_W'(5 + a[5:2]);
        return s;
    endfunction

    // Reset value of a configuration slot.
    function automatic logic [DW-1:0] slot_rst(input int s);
        return (s == BUSOPT_SLOT) ? BUSOPT_RST : '0;
    endfunction
endpackage

// File: rtl/dpy_cfg_file.sv
// Configuration word store: NSLOT plain read/write words, one write port,
// one combinational read port, all words exposed on a flat bus.
// Assumes the caller has already qualified the write enable.
module dpy_cfg_file
    import dpy_regs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SLOT_W-1:0]     wslot,
    input  logic [DW-1:0]         wdata,
    input  logic [SLOT_W-1:0]     rslot,
    output logic [DW-1:0]         rdata,
    output logic [NSLOT*DW-1:0]   cfg_flat
);
    logic [DW-1:0] q [NSLOT];

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        // Hold one configuration word; load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                               q[i] <= slot_rst(i);
            else if (we && wslot == SLOT_W'(i))       q[i] <= wdata;
        end
        assign cfg_flat[i*DW +: DW] = q[i];

        // R4 R10
        slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(we && wslot == SLOT_W'(i)) |-> $stable(q[i]));
    end

    // Read port: select the addressed slot.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NSLOT; k++)
            if (rslot == SLOT_W'(k)) rdata = q[k];
    end
endmodule

// File: rtl/dpy_irq_ctrl.sv
// Interrupt state: raw status (software set/clear plus hardware strobes),
// mask, masked status and the level interrupt line.
// Assumes set and clear writes never occur in the same cycle.
module dpy_irq_ctrl
    import dpy_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] wbits,
    input  logic [IRQ_W-1:0] hw_evt,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] stat,
    output logic             irq_o
);
    logic [IRQ_W-1:0] set_bits, clr_bits;

    // Software set/clear vectors for this cycle.
    always_comb begin
        set_bits = set_we ? wbits : '0;
        clr_bits = clr_we ? wbits : '0;
    end

    // Raw status update; hardware strobes win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= ((raw | set_bits) & ~clr_bits) | hw_evt;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wbits;
    end

    assign stat  = raw & mask;
    assign irq_o = |stat;

    // R5
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_we) |-> ((raw & $past(wbits)) == $past(wbits)));
    // R6
    raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_we) |-> ((raw & $past(wbits) & ~$past(hw_evt)) == '0));
    // R8
    hw_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|hw_evt) |-> ((raw & $past(hw_evt)) == $past(hw_evt)));
    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(set_we || mask_we || (|hw_evt)));
endmodule

// File: rtl/dpy_cmd_reg.sv
// Command word with enable in bit 0; emits one-cycle start/stop pulses
// only when a write changes the enable bit.
// Assumes the write enable is already qualified.
module dpy_cmd_reg
    import dpy_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cmd,
    output logic          start_pulse,
    output logic          stop_pulse
);
    // Store the command word and derive the edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd         <= '0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
        end else begin
            start_pulse <= we &&  wdata[0] && !cmd[0];
            stop_pulse  <= we && !wdata[0] &&  cmd[0];
            if (we) cmd <= wdata;
        end
    end

    // R9
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (cmd[0] && !$past(cmd[0])));
    // R9
    stop_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (!cmd[0] && $past(cmd[0])));
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));
endmodule

// File: rtl/dpy_ctrl_regs.sv
// Top of the display controller register and interrupt block. Decodes the
// request port, routes writes to the configuration store, the interrupt
// state and the command word, and returns a registered response.
// Assumes at most one request per cycle; no back-pressure.
module dpy_ctrl_regs
    import dpy_regs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [2:0]           req_bytes,
    input  logic [DW-1:0]        req_wdata,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    output logic                 rsp_err,
    input  logic                 evt_dma_end,
    input  logic                 evt_vsync,
    input  logic                 evt_underrun,
    output logic                 irq_o,
    output logic                 ctrl_on,
    output logic                 start_pulse,
    output logic                 stop_pulse,
    output logic [NSLOT*DW-1:0]  cfg_flat
);
    acc_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic              bad, wr_ok;
    logic [DW-1:0]     cfg_rd, cmd, rd_mux;
    logic [IRQ_W-1:0]  raw, mask, stat, hw_evt;

    // Request classification and legality.
    always_comb begin
        kind  = kind_of(req_addr);
        slot  = slot_of(req_addr);
        bad   = (req_bytes != 3'd4) || (kind == K_NONE)
             || ( req_write && (kind == K_ID || kind == K_STAT))
             || (!req_write && kind == K_CLR);
        wr_ok = req_valid && req_write && !bad;
    end

    // Hardware event strobes placed on their raw status bits.
    always_comb begin
        hw_evt               = '0;
        hw_evt[IRQ_DMA_END]  = evt_dma_end;
        hw_evt[IRQ_VSYNC]    = evt_vsync;
        hw_evt[IRQ_UNDERRUN] = evt_underrun;
    end

    dpy_cfg_file i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_ok && kind == K_CFG),
        .wslot    (slot),
        .wdata    (req_wdata),
        .rslot    (slot),
        .rdata    (cfg_rd),
        .cfg_flat (cfg_flat)
    );

    dpy_irq_ctrl i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (wr_ok && kind == K_RAW),
        .clr_we  (wr_ok && kind == K_CLR),
        .mask_we (wr_ok && kind == K_MASK),
        .wbits   (req_wdata[IRQ_W-1:0]),
        .hw_evt  (hw_evt),
        .raw     (raw),
        .mask    (mask),
        .stat    (stat),
        .irq_o   (irq_o)
    );

    dpy_cmd_reg i_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (wr_ok && kind == K_CMD),
        .wdata       (req_wdata),
        .cmd         (cmd),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse)
    );

    assign ctrl_on = cmd[0];

    // Read data selection by register kind.
    always_comb begin
        case (kind)
            K_ID:    rd_mux = ID_VALUE;
            K_RAW:   rd_mux = DW'(raw);
            K_MASK:  rd_mux = DW'(mask);
            K_STAT:  rd_mux = DW'(stat);
            K_CMD:   rd_mux = cmd;
            K_CFG:   rd_mux = cfg_rd;
            default: rd_mux = '0;
        endcase
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && bad;
            rsp_rdata <= (req_valid && !req_write && !bad) ? rd_mux : '0;
        end
    end

    // R1
    size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_bytes != 3'd4) |-> rsp_err);
    // R10
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));
    // R11
    rsp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    // R2
    id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write && req_addr == '0 && req_bytes == 3'd4)
        |-> (rsp_rdata == ID_VALUE));
endmodule

// File: tb/test_dpy_ctrl_regs.sv
module test_dpy_ctrl_regs;
    logic         clk = 0, rst_n = 0;
    logic         req_valid = 0, req_write = 0;
    logic [11:0]  req_addr = 0;
    logic [2:0]   req_bytes = 4;
    logic [31:0]  req_wdata = 0;
    logic         rsp_valid, rsp_err, irq_o, ctrl_on, start_pulse, stop_pulse;
    logic [31:0]  rsp_rdata;
    logic         evt_dma_end = 0, evt_vsync = 0, evt_underrun = 0;
    logic [18*32-1:0] cfg_flat;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Bench-side model.
    logic [31:0] m_cfg [0:1023];
    logic [3:0]  m_raw = 0, m_mask = 0;
    logic [31:0] m_cmd = 0;
    logic        s_start, s_stop, s_irq;

    always #10 clk = ~clk;

    dpy_ctrl_regs i_dpy_ctrl_regs (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_bytes, .req_wdata,
        .rsp_valid, .rsp_rdata, .rsp_err, .evt_dma_end, .evt_vsync, .evt_underrun,
        .irq_o, .ctrl_on, .start_pulse, .stop_pulse, .cfg_flat
    );

    function automatic bit is_cfg(input int a);
        return (a >= 'h100 && a <= 'h110 && a % 4 == 0) ||
               (a >= 'h200 && a <= 'h220 && a % 4 == 0) ||
               (a >= 'h240 && a <= 'h24C && a % 4 == 0);
    endfunction

    function automatic bit is_def(input int a);
        return is_cfg(a) || a == 0 || a == 'h10 || a == 'h14 || a == 'h18 ||
               a == 'h1C || a == 'h230;
    endfunction

    function automatic logic [31:0] exp_rd(input int a);
        if (a == 0)     return 32'h0001_0200;
        if (a == 'h10)  return {28'd0, m_raw};
        if (a == 'h18)  return {28'd0, m_mask};
        if (a == 'h1C)  return {28'd0, m_raw & m_mask};
        if (a == 'h230) return m_cmd;
        if (is_cfg(a))  return m_cfg[a];
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input int a, input logic [31:0] d,
                       input logic [2:0] sz, input logic [2:0] ev,
                       output logic [31:0] rd, output bit er);
        @(negedge clk);
        if (rsp_valid) check(0, "R11", 1, 0);
        req_valid = 1; req_write = wr; req_addr = 12'(a); req_bytes = sz;
        req_wdata = d;
        {evt_underrun, evt_vsync, evt_dma_end} = ev;
        @(negedge clk);
        req_valid = 0; {evt_underrun, evt_vsync, evt_dma_end} = 0;
        if (!rsp_valid) check(0, "R11", 0, 1);
        rd = rsp_rdata; er = rsp_err;
        s_start = start_pulse; s_stop = stop_pulse; s_irq = irq_o;
    endtask

    task automatic rd_chk(input int a, input string req);
        logic [31:0] rd; bit er;
        acc(0, a, 0, 4, 0, rd, er);
        check(rd == exp_rd(a) && !er, req, rd, exp_rd(a));
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        logic [31:0] rd; bit er;
        acc(1, a, d, 4, 0, rd, er);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd; bit er;
        for (int i = 0; i < 1024; i++) m_cfg[i] = 0;
        m_cfg['h110] = 32'h0000_0410;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R3: reset values at every defined offset, plus line and pulses.
        check(!irq_o && !ctrl_on && !start_pulse && !stop_pulse, "R3",
              {irq_o, ctrl_on, start_pulse, stop_pulse}, 0);
        for (int a = 0; a < 'h300; a += 4)
            if (is_def(a) && a != 'h14) rd_chk(a, "R3");

        // R4: distinct pattern into every configuration word, then read back.
        for (int a = 0; a < 'h300; a += 4)
            if (is_cfg(a)) begin
                m_cfg[a] = 32'hA5C3_0000 ^ (a * 32'h0101_0101);
                wr(a, m_cfg[a]);
            end
        for (int a = 0; a < 'h300; a += 4)
            if (is_cfg(a)) rd_chk(a, "R4");
        check(cfg_flat[31:0] == m_cfg['h100], "R4 slot0", cfg_flat[31:0], m_cfg['h100]);
        check(cfg_flat[17*32 +: 32] == m_cfg['h24C], "R4 slot17",
              cfg_flat[17*32 +: 32], m_cfg['h24C]);

        // R1: every illegal size, read and write, on a writable word.
        for (int s = 0; s < 8; s++)
            if (s != 4) begin
                acc(1, 'h104, 32'hDEAD_BEEF, 3'(s), 0, rd, er);
                check(er && rd == 0, "R1 write", {31'd0, er}, 1);
                acc(0, 'h104, 0, 3'(s), 0, rd, er);
                check(er && rd == 0, "R1 read", rd, 0);
            end
        rd_chk('h104, "R1");

        // R2: identifier is read-only.
        acc(1, 0, 32'hFFFF_FFFF, 4, 0, rd, er);
        check(er, "R2 write err", {31'd0, er}, 1);
        rd_chk(0, "R2");

        // R10: every byte offset naming no register, written then read.
        for (int a = 0; a < 'h300; a++)
            if (!is_def(a)) begin
                acc(1, a, 32'hFFFF_FFFF, 4, 0, rd, er);
                check(er && rd == 0, "R10 write", {31'd0, er}, 1);
                acc(0, a, 0, 4, 0, rd, er);
                check(er && rd == 0, "R10 read", rd, 0);
            end
        for (int a = 0; a < 'h300; a += 4)
            if (is_def(a) && a != 'h14) rd_chk(a, "R10 untouched");

        // R5 R7: every mask against every raw pattern.
        for (int m = 0; m < 16; m++)
            for (int p = 0; p < 16; p++) begin
                wr('h14, 32'hF); m_raw = 0;
                wr('h18, 32'(m)); m_mask = 4'(m);
                wr('h10, 32'hFFFF_FFF0 | 32'(p)); m_raw = 4'(p);
                check(s_irq == |(m_raw & m_mask), "R7 irq", {31'd0, s_irq},
                      {31'd0, |(m_raw & m_mask)});
                rd_chk('h1C, "R7");
            end
        rd_chk('h10, "R5");
        // R5: set is cumulative.
        wr('h14, 32'hF); wr('h10, 1); wr('h10, 4); m_raw = 4'h5;
        rd_chk('h10, "R5 accumulate");

        // R6: selective clear; clear is unreadable.
        wr('h14, 32'h1); m_raw = 4'h4;
        rd_chk('h10, "R6");
        acc(0, 'h14, 0, 4, 0, rd, er);
        check(er && rd == 0, "R6 read err", rd, 0);
        // R7: masked status write is ignored.
        acc(1, 'h1C, 32'hF, 4, 0, rd, er);
        check(er, "R7 write err", {31'd0, er}, 1);
        rd_chk('h1C, "R7 after write");

        // R8: each event strobe alone, then R6 clear racing underrun.
        wr('h18, 32'hF); m_mask = 4'hF;
        for (int e = 0; e < 3; e++) begin
            wr('h14, 32'hF); m_raw = 0;
            acc(0, 'h08, 0, 4, 3'(1 << e), rd, er);
            m_raw = (e == 0) ? 4'h1 : (e == 1) ? 4'h4 : 4'h8;
            check(irq_o, "R8 irq", {31'd0, irq_o}, 1);
            rd_chk('h10, "R8");
        end
        acc(1, 'h14, 32'hF, 4, 3'b100, rd, er); m_raw = 4'h8;
        rd_chk('h10, "R6 event wins");
        wr('h14, 32'hF); m_raw = 0;
        check(!irq_o, "R7 irq low", {31'd0, irq_o}, 0);

        // R9: enable transitions and pulses.
        begin
            logic [31:0] seq [7] = '{32'h0, 32'h1, 32'h1, 32'h3, 32'h2, 32'h0, 32'h1};
            for (int k = 0; k < 7; k++) begin
                bit es, ep;
                es = seq[k][0] && !m_cmd[0];
                ep = !seq[k][0] && m_cmd[0];
                acc(1, 'h230, seq[k], 4, 0, rd, er);
                m_cmd = seq[k];
                check(s_start == es && s_stop == ep, "R9 pulse",
                      {30'd0, s_start, s_stop}, {30'd0, es, ep});
                @(negedge clk);
                check(!start_pulse && !stop_pulse && ctrl_on == m_cmd[0],
                      "R9 one cycle", {30'd0, start_pulse, stop_pulse}, 0);
                rd_chk('h230, "R9");
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule